// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Controller

This block runs one read or write transfer at a time on a bus whose low sixteen lines carry both address and data. It suits a system with a single bus master. The requester presents a 20-bit address, a word/byte flag, a direction and a memory/I-O select. The controller then steps through the bus cycle by itself. It drives the address in the first clock and pulses a latch strobe so that external latches can capture the address. In the following clocks it asserts the read or write strobe, enables the external data transceiver and sets that transceiver's direction. It stretches the transfer with wait clocks for as long as the addressed device holds its ready line low.

In the first clock, the upper four lines carry address bits 19..16. After that they carry a small status code. For a read, the shared lines are released once the address clock ends, and the value on them is captured at the end of the data clock. The end clock raises a one-clock completion pulse, and the controller accepts a new request on the clock after it.

Top module: `mux_bus_seq`

## Requirements
- R1: After reset: `req_ready`=1, `ale`=0, `rd_n`=`wr_n`=`den_n`=`bhe_n`=1, `ad_oe`=0, `done`=0, `mio`=0, `dt_r`=0.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. The next clock is the address clock. In it, `ale`=1 for exactly that one clock, `ad_out`=addr[15:0], `ad_oe`=1 and `as_out`=addr[19:16].
- R3: In every later clock of the cycle, `as_out` carries the status code {0, 0, mem, write}: bit 1 is the memory select and bit 0 is the direction.
- R4: A read drives `rd_n` low and a write drives `wr_n` low. The strobe starts in the clock after the address clock and stays low for 2 + W clocks, where W is the number of wait clocks. The two strobes are never low together.
- R5: When `ready` is 0 at the end of the strobe-assert clock or of a wait clock, one more wait clock follows. When `ready` is 1 at that point, the data clock follows.
- R6: `dt_r` is 1 for a write and 0 for a read throughout the cycle. `den_n` is 0 in exactly the clocks in which a strobe is low.
- R7: During a write's strobe clocks, `ad_oe`=1 and `ad_out`=wdata. During a read's strobe clocks, `ad_oe`=0.
- R8: `bhe_n` is 0 for the whole cycle for a word access or for a byte access at an odd address. It is 1 for a byte access at an even address.
- R9: `mio` is 1 for a memory access and 0 for an I/O access throughout the cycle.
- R10: `done` is 1 for exactly one clock, the clock right after the strobe rises. For a read, `rdata` then holds the value `ad_in` carried in the data clock. `req_ready` returns to 1 in the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Controller idle, request may be accepted |
| req_addr | input | 20 | Transfer address |
| req_word | input | 1 | 1 = word transfer, 0 = byte transfer |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory space, 0 = I/O space |
| req_wdata | input | 16 | Write data |
| rdata | output | 16 | Read data captured from the bus |
| done | output | 1 | One-clock completion pulse |
| ad_out | output | 16 | Shared address/data lines, driven value |
| ad_oe | output | 1 | Output enable of the shared lines |
| ad_in | input | 16 | Shared address/data lines, received value |
| as_out | output | 4 | Upper address / status lines |
| ale | output | 1 | Address latch strobe, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| den_n | output | 1 | Transceiver enable, active low |
| dt_r | output | 1 | Transceiver direction, 1 = outward |
| bhe_n | output | 1 | Upper byte lane enable, active low |
| mio | output | 1 | 1 = memory, 0 = I/O |
| ready | input | 1 | Device ready; low inserts wait clocks |

## Verification
The cycle is exercised with word and byte transfers at even and odd addresses, in both directions and in both address spaces, and with 0, 1, 3 and 5 wait clocks. The byte cases at even and odd addresses tell the two cases of the upper-lane enable apart. The differing wait counts show whether the strobe length follows `ready` or a fixed count. Pairing reads with writes separates the two strobes, the transceiver direction and the release of the shared lines. One transfer uses the all-ones address, which confirms that the top address bits reach the upper lines unmixed with status.

// File: rtl/mux_bus_seq.sv
module mux_bus_seq #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_word,
  input  logic          req_write,
  input  logic          req_mem,
  input  logic [DW-1:0] req_wdata,
  output logic [DW-1:0] rdata,
  output logic          done,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  input  logic [DW-1:0] ad_in,
  output logic [AW-DW-1:0] as_out,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic          den_n,
  output logic          dt_r,
  output logic          bhe_n,
  output logic          mio,
  input  logic          ready
);
  localparam int HW = AW - DW;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_STRB, S_WAIT, S_DATA, S_END} st_t;

  st_t           st;
  logic [AW-1:0] c_addr;
  logic [DW-1:0] c_wdata;
  logic          c_word, c_write, c_mem;
  logic          strobing, busy;
  logic [HW-1:0] status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      c_addr  <= '0;
      c_wdata <= '0;
      c_word  <= 1'b0;
      c_write <= 1'b0;
      c_mem   <= 1'b0;
      rdata   <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          st      <= S_ADDR;
          c_addr  <= req_addr;
          c_wdata <= req_wdata;
          c_word  <= req_word;
          c_write <= req_write;
          c_mem   <= req_mem;
        end
        S_ADDR: st <= S_STRB;
        S_STRB, S_WAIT: st <= ready ? S_DATA : S_WAIT;
        S_DATA: begin
          st <= S_END;
          if (!c_write) rdata <= ad_in;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    status    = '0;
    status[1] = c_mem;
    status[0] = c_write;
  end

  assign busy      = (st != S_IDLE);
  assign strobing  = (st == S_STRB) || (st == S_WAIT) || (st == S_DATA);
  assign req_ready = !busy;
  assign done      = (st == S_END);
  assign ale       = (st == S_ADDR);
  assign ad_out    = (st == S_ADDR) ? c_addr[DW-1:0] : c_wdata;
  assign ad_oe     = (st == S_ADDR) || (strobing && c_write);
  assign as_out    = (st == S_ADDR) ? c_addr[AW-1:DW] : (busy ? status : '0);
  assign rd_n      = !(strobing && !c_write);
  assign wr_n      = !(strobing && c_write);
  assign den_n     = !strobing;
  assign dt_r      = busy && c_write;
  assign bhe_n     = !(busy && (c_word || c_addr[0]));
  assign mio       = busy && c_mem;
endmodule

// File: rtl/mux_bus_seq_chk.sv
module mux_bus_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic done,
  input logic ad_oe,
  input logic ale,
  input logic rd_n,
  input logic wr_n,
  input logic den_n,
  input logic dt_r,
  input logic bhe_n,
  input logic ready
);
  // R4
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  // R2
  ale_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  // R4
  ale_then_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> (!rd_n || !wr_n));

  // R5
  wait_hold_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rd_n) && !ready) |=> !rd_n);

  // R5
  wait_hold_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(wr_n) && !ready) |=> !wr_n);

  // R7
  read_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);

  // R6
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> (dt_r && !den_n));

  // R6
  dir_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> (!dt_r && !den_n));

  // R8
  bhe_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> $stable(bhe_n));

  // R10
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rd_n && wr_n && den_n));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready));
endmodule

bind mux_bus_seq mux_bus_seq_chk i_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done(done),
  .ad_oe(ad_oe), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .den_n(den_n),
  .dt_r(dt_r), .bhe_n(bhe_n), .ready(ready)
);

// File: tb/test_mux_bus_seq.sv
module test_mux_bus_seq;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [19:0] req_addr = '0;
  logic        req_word = 1'b0, req_write = 1'b0, req_mem = 1'b0;
  logic [15:0] req_wdata = '0;
  logic [15:0] rdata, ad_out, ad_in = '0;
  logic        done, ad_oe, ale, rd_n, wr_n, den_n, dt_r, bhe_n, mio;
  logic [3:0]  as_out;
  logic        ready = 1'b1;

  int total = 0;
  int bad = 0;

  always #(PERIOD/2) clk = !clk;

  mux_bus_seq i_mux_bus_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_word(req_word), .req_write(req_write),
    .req_mem(req_mem), .req_wdata(req_wdata), .rdata(rdata), .done(done),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .as_out(as_out),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .den_n(den_n), .dt_r(dt_r),
    .bhe_n(bhe_n), .mio(mio), .ready(ready)
  );

  task automatic chk(input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: got %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic run(input logic [19:0] a, input logic wd, input logic wr,
                     input logic mem, input logic [15:0] wdat,
                     input logic [15:0] rval, input int nwait);
    int nstr = 0;
    int rem = nwait;
    logic ebhe = !(wd || a[0]);
    @(negedge clk);
    req_addr = a; req_word = wd; req_write = wr; req_mem = mem;
    req_wdata = wdat; ad_in = rval; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2", "ale", ale, 1);
    chk("R2", "ad_out addr", ad_out, a[15:0]);
    chk("R2", "ad_oe addr", ad_oe, 1);
    chk("R2", "as_out addr", as_out, a[19:16]);
    chk("R2", "req_ready busy", req_ready, 0);
    chk("R8", "bhe_n addr", bhe_n, ebhe);
    chk("R9", "mio addr", mio, mem);
    chk("R6", "dt_r addr", dt_r, wr);
    for (int g = 0; g < 40; g++) begin
      @(negedge clk);
      if ((wr ? wr_n : rd_n) == 1'b1) break;
      nstr++;
      chk("R4", "other strobe", wr ? rd_n : wr_n, 1);
      chk("R2", "ale off", ale, 0);
      chk("R3", "status", as_out, {2'b00, mem, wr});
      chk("R6", "dt_r", dt_r, wr);
      chk("R6", "den_n", den_n, 0);
      chk("R7", "ad_oe", ad_oe, wr);
      if (wr) chk("R7", "ad_out wdata", ad_out, wdat);
      chk("R8", "bhe_n", bhe_n, ebhe);
      chk("R9", "mio", mio, mem);
      chk("R10", "done early", done, 0);
      if (rem > 0) begin ready = 1'b0; rem--; end
      else ready = 1'b1;
    end
    ready = 1'b1;
    chk("R5", "strobe clocks", nstr, nwait + 2);
    chk("R4", "strobes high at end", {rd_n, wr_n}, 2'b11);
    chk("R6", "den_n end", den_n, 1);
    chk("R10", "done", done, 1);
    chk("R8", "bhe_n end", bhe_n, ebhe);
    if (!wr) chk("R10", "rdata", rdata, rval);
    @(negedge clk);
    chk("R10", "done cleared", done, 0);
    chk("R10", "req_ready back", req_ready, 1);
    chk("R1", "bhe_n idle", bhe_n, 1);
  endtask

  task automatic t_reset;
    chk("R1", "req_ready", req_ready, 1);
    chk("R1", "ale", ale, 0);
    chk("R1", "strobes", {rd_n, wr_n, den_n, bhe_n}, 4'hF);
    chk("R1", "ad_oe", ad_oe, 0);
    chk("R1", "done", done, 0);
    chk("R1", "mio dt_r", {mio, dt_r}, 2'b00);
  endtask

  task automatic t_word_mem_read;  run(20'h3_1234, 1, 0, 1, 16'h0000, 16'hBEEF, 0); endtask
  task automatic t_byte_io_write;  run(20'h0_0042, 0, 1, 0, 16'h00A5, 16'h0000, 1); endtask
  task automatic t_odd_byte_read;  run(20'hA_5557, 0, 0, 1, 16'h0000, 16'h7C00, 3); endtask
  task automatic t_top_word_write; run(20'hF_FFFF, 1, 1, 1, 16'h5AC3, 16'h0000, 5); endtask
  task automatic t_even_io_read;   run(20'h5_0FF0, 0, 0, 0, 16'h0000, 16'h0091, 2); endtask

  initial begin
    #(PERIOD * 100000);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_word_mem_read();
    t_byte_io_write();
    t_odd_byte_read();
    t_top_word_write();
    t_even_io_read();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule